// File: doc/BRIEF.md
# MSI Snooping Cache-Line Controller

This block is the coherence engine of a small direct-mapped write-back cache on a shared snooping bus. Each line holds a tag, a data block of several words and one of three coherence states: Modified (dirty, sole owner), Shared (clean, possibly held elsewhere) or Invalid. The processor side issues word reads and writes and holds each request until the controller raises its ready signal. Hits in a permitted state complete in the same cycle. Every other access becomes one bus transaction, or two when a dirty victim must be written back first.

The bus side has a request/grant pair and a completion strobe from the memory responder. A transaction runs after its grant and ends when the responder signals done. Fills arrive as whole lines. The controller also watches bus transactions from other caches. When a snoop hits a line it updates that line's state. When the line is dirty, it places the full line on the flush outputs in the same cycle.

Coherence is tracked per line. A snoop names a line address, never a word.

Top module: `msi_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid, `bus_req`, `cpu_ready` and `snp_flush` are low, and the first access to any address misses.
- R2: A processor read that misses, because the line is Invalid or holds another tag, issues a bus read (`bus_cmd` = 1) for the line address. The fill installs the line as Shared and the read then completes with the filled word.
- R3: A processor write to an Invalid or Shared line issues a bus read-exclusive (`bus_cmd` = 2). The fill installs the line as Modified and the write word is merged into it.
- R4: A read hit in Shared or Modified, or a write hit in Modified, raises `cpu_ready` in the cycle of the request and produces no bus request.
- R5: A snooped bus read (`snp_cmd` = 1) that hits a Modified line drives `snp_flush` high with the whole line on `snp_data` in that cycle and leaves the line Shared, so a later processor write needs a read-exclusive.
- R6: A snooped read-exclusive (`snp_cmd` = 2) that hits a Modified line flushes the line and leaves it Invalid.
- R7: A snooped read-exclusive on a Shared line leaves it Invalid with no flush. A snooped bus read on a Shared line flushes nothing and leaves the line Shared.
- R8: A miss whose index holds a Modified line with another tag first issues a write-back (`bus_cmd` = 3) carrying the victim's line address and data. The fetch of the requested line follows.
- R9: While a transaction is pending or in flight, `cpu_ready` stays low. An ungranted `bus_req` keeps its command and address stable until `bus_gnt` arrives, and the transaction ends on `bus_done`.
- R10: A snoop that hits the index of a pending, not yet granted transaction is applied first and the request is withdrawn. The processor access is then re-evaluated against the new state, so a write-back made needless by a snoop flush is dropped.
- R11: In any cycle with `snp_valid` high, `cpu_ready` is low, so the snoop takes priority over a same-cycle hit.
- R12: A snoop whose tag does not match the stored line, or that targets an Invalid line, changes no state and flushes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address {tag, index, word offset} |
| cpu_wdata | input | WORD_W | Write word |
| cpu_rdata | output | WORD_W | Read word, valid with `cpu_ready` |
| cpu_ready | output | 1 | Request completes this cycle |
| bus_req | output | 1 | Request for the bus |
| bus_gnt | input | 1 | Grant for the pending request |
| bus_cmd | output | 2 | 0 none, 1 read, 2 read-exclusive, 3 write-back |
| bus_addr | output | ADDR_W-OFF_W | Line address of the transaction |
| bus_wdata | output | LINE_W | Victim line for a write-back |
| bus_done | input | 1 | Responder completion |
| bus_rdata | input | LINE_W | Fill line, valid with `bus_done` |
| snp_valid | input | 1 | Another master's transaction is on the bus |
| snp_cmd | input | 2 | 1 read, 2 read-exclusive |
| snp_addr | input | ADDR_W-OFF_W | Snooped line address |
| snp_flush | output | 1 | This cache supplies the dirty line |
| snp_data | output | LINE_W | Flushed line |

## Verification
Processor accesses are tried as cold misses, as hits in each permitted state, and as upgrades from Shared. These patterns tell a same-cycle hit apart from a needless transaction and separate a read from a read-exclusive. Snoops of both kinds are aimed at Modified, Shared, Invalid and tag-mismatched lines, which distinguishes flush from silent invalidation and from no effect. A conflict miss on a dirty line checks the write-back ordering and its data, which must later come back through a refill. A snoop injected while a write-back waits for grant shows that the request is withdrawn and re-decided without the write-back.

// File: rtl/msi_pkg.sv
package msi_pkg;
    // coherence state of a line
    localparam logic [1:0] COH_I = 2'd0;
    localparam logic [1:0] COH_S = 2'd1;
    localparam logic [1:0] COH_M = 2'd2;

    // bus transaction codes
    localparam logic [1:0] BUS_NONE = 2'd0;
    localparam logic [1:0] BUS_RD   = 2'd1;
    localparam logic [1:0] BUS_RDX  = 2'd2;
    localparam logic [1:0] BUS_WB   = 2'd3;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_REQ  = 2'd1,
        PH_XFER = 2'd2
    } phase_e;
endpackage

// File: rtl/msi_snoop_resp.sv
module msi_snoop_resp
    import msi_pkg::*;
(
    input  logic       snp_valid,
    input  logic [1:0] snp_cmd,
    input  logic [1:0] line_st,
    input  logic       tag_eq,
    output logic       hit,
    output logic       flush,
    output logic       upd,
    output logic [1:0] nxt_st
);
    always_comb begin
        hit    = snp_valid && tag_eq && (line_st != COH_I)
                 && ((snp_cmd == BUS_RD) || (snp_cmd == BUS_RDX));
        flush  = hit && (line_st == COH_M);
        upd    = 1'b0;
        nxt_st = line_st;
        if (hit) begin
            if (snp_cmd == BUS_RDX) begin
                upd    = 1'b1;
                nxt_st = COH_I;
            end else if (line_st == COH_M) begin
                upd    = 1'b1;
                nxt_st = COH_S;
            end
        end
    end
endmodule

// File: rtl/msi_line_store.sv
module msi_line_store #(
    parameter int LINES  = 4,
    parameter int TAG_W  = 9,
    parameter int LINE_W = 64,
    parameter int RPORTS = 2,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [RPORTS-1:0][IDX_W-1:0]       rd_idx,
    output logic [RPORTS-1:0][1:0]             rd_st,
    output logic [RPORTS-1:0][TAG_W-1:0]       rd_tag,
    output logic [RPORTS-1:0][LINE_W-1:0]      rd_line,
    input  logic                               wr_en,
    input  logic [IDX_W-1:0]                   wr_idx,
    input  logic [1:0]                         wr_st,
    input  logic                               wr_set_tag,
    input  logic [TAG_W-1:0]                   wr_tag,
    input  logic                               wr_set_data,
    input  logic [LINE_W-1:0]                  wr_line
);
    typedef struct packed {
        logic [LINES-1:0][1:0]        st;
        logic [LINES-1:0][TAG_W-1:0]  tag;
        logic [LINES-1:0][LINE_W-1:0] data;
    } store_t;

    store_t store_d, store_q;

    always_comb begin
        store_d = store_q;
        if (wr_en) begin
            store_d.st[wr_idx] = wr_st;
            if (wr_set_tag)  store_d.tag[wr_idx]  = wr_tag;
            if (wr_set_data) store_d.data[wr_idx] = wr_line;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) store_q <= '0;
        else        store_q <= store_d;
    end

    for (genvar p = 0; p < RPORTS; p++) begin : g_rport
        assign rd_st[p]   = store_q.st[rd_idx[p]];
        assign rd_tag[p]  = store_q.tag[rd_idx[p]];
        assign rd_line[p] = store_q.data[rd_idx[p]];
    end
endmodule

// File: rtl/msi_cache_ctrl.sv
module msi_cache_ctrl
    import msi_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 2,
    parameter int LINES      = 4,
    localparam int OFF_W   = $clog2(LINE_WORDS),
    localparam int IDX_W   = $clog2(LINES),
    localparam int TAG_W   = ADDR_W - OFF_W - IDX_W,
    localparam int LINE_W  = WORD_W * LINE_WORDS,
    localparam int LADDR_W = ADDR_W - OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_req,
    input  logic               cpu_we,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [WORD_W-1:0]  cpu_wdata,
    output logic [WORD_W-1:0]  cpu_rdata,
    output logic               cpu_ready,
    output logic               bus_req,
    input  logic               bus_gnt,
    output logic [1:0]         bus_cmd,
    output logic [LADDR_W-1:0] bus_addr,
    output logic [LINE_W-1:0]  bus_wdata,
    input  logic               bus_done,
    input  logic [LINE_W-1:0]  bus_rdata,
    input  logic               snp_valid,
    input  logic [1:0]         snp_cmd,
    input  logic [LADDR_W-1:0] snp_addr,
    output logic               snp_flush,
    output logic [LINE_W-1:0]  snp_data
);
    typedef struct packed {
        phase_e             ph;
        logic [1:0]         cmd;
        logic [LADDR_W-1:0] addr;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    // address fields
    logic [IDX_W-1:0] cpu_idx, snp_idx, pend_idx;
    logic [TAG_W-1:0] cpu_tag, snp_tag;
    logic [OFF_W-1:0] cpu_off;

    assign cpu_off  = cpu_addr[OFF_W-1:0];
    assign cpu_idx  = cpu_addr[OFF_W +: IDX_W];
    assign cpu_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
    assign snp_idx  = snp_addr[IDX_W-1:0];
    assign snp_tag  = snp_addr[LADDR_W-1 -: TAG_W];
    assign pend_idx = ctrl_q.addr[IDX_W-1:0];

    // line store: port 0 processor/victim side, port 1 snoop side
    logic [1:0][IDX_W-1:0]  rd_idx;
    logic [1:0][1:0]        rd_st;
    logic [1:0][TAG_W-1:0]  rd_tag;
    logic [1:0][LINE_W-1:0] rd_line;
    logic                   wr_en, wr_set_tag, wr_set_data;
    logic [IDX_W-1:0]       wr_idx;
    logic [1:0]             wr_st;
    logic [TAG_W-1:0]       wr_tag;
    logic [LINE_W-1:0]      wr_line;

    assign rd_idx[0] = (ctrl_q.ph == PH_IDLE) ? cpu_idx : pend_idx;
    assign rd_idx[1] = snp_idx;

    msi_line_store #(
        .LINES (LINES),
        .TAG_W (TAG_W),
        .LINE_W(LINE_W),
        .RPORTS(2)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_idx     (rd_idx),
        .rd_st      (rd_st),
        .rd_tag     (rd_tag),
        .rd_line    (rd_line),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_st      (wr_st),
        .wr_set_tag (wr_set_tag),
        .wr_tag     (wr_tag),
        .wr_set_data(wr_set_data),
        .wr_line    (wr_line)
    );

    // snoop decode
    logic       s_hit, s_flush, s_upd;
    logic [1:0] s_nst;

    msi_snoop_resp u_snoop (
        .snp_valid(snp_valid),
        .snp_cmd  (snp_cmd),
        .line_st  (rd_st[1]),
        .tag_eq   (rd_tag[1] == snp_tag),
        .hit      (s_hit),
        .flush    (s_flush),
        .upd      (s_upd),
        .nxt_st   (s_nst)
    );

    assign snp_flush = s_flush;
    assign snp_data  = rd_line[1];

    // processor-side hit decode
    logic             tag_hit, can_hit, victim_dirty;
    logic [LINE_W-1:0] merged;

    assign tag_hit      = (rd_st[0] != COH_I) && (rd_tag[0] == cpu_tag);
    assign can_hit      = tag_hit && ((rd_st[0] == COH_M) || (!cpu_we && rd_st[0] == COH_S));
    assign victim_dirty = (rd_st[0] == COH_M) && (rd_tag[0] != cpu_tag);

    assign cpu_ready = (ctrl_q.ph == PH_IDLE) && cpu_req && !snp_valid && can_hit;
    assign cpu_rdata = rd_line[0][cpu_off*WORD_W +: WORD_W];

    always_comb begin
        merged = rd_line[0];
        merged[cpu_off*WORD_W +: WORD_W] = cpu_wdata;
    end

    // bus outputs
    assign bus_req   = (ctrl_q.ph == PH_REQ);
    assign bus_cmd   = (ctrl_q.ph == PH_IDLE) ? BUS_NONE : ctrl_q.cmd;
    assign bus_addr  = ctrl_q.addr;
    assign bus_wdata = rd_line[0];

    // next-state logic
    always_comb begin
        ctrl_d      = ctrl_q;
        wr_en       = 1'b0;
        wr_idx      = cpu_idx;
        wr_st       = rd_st[0];
        wr_set_tag  = 1'b0;
        wr_tag      = cpu_tag;
        wr_set_data = 1'b0;
        wr_line     = merged;

        // store update, snoop first
        if (snp_valid && s_upd) begin
            wr_en  = 1'b1;
            wr_idx = snp_idx;
            wr_st  = s_nst;
        end else if (ctrl_q.ph == PH_XFER && bus_done) begin
            wr_en  = 1'b1;
            wr_idx = pend_idx;
            if (ctrl_q.cmd == BUS_WB) begin
                wr_st = COH_I;
            end else begin
                wr_st       = (ctrl_q.cmd == BUS_RDX) ? COH_M : COH_S;
                wr_set_tag  = 1'b1;
                wr_tag      = ctrl_q.addr[LADDR_W-1 -: TAG_W];
                wr_set_data = 1'b1;
                wr_line     = bus_rdata;
            end
        end else if (cpu_ready && cpu_we) begin
            wr_en       = 1'b1;
            wr_idx      = cpu_idx;
            wr_st       = COH_M;
            wr_set_data = 1'b1;
            wr_line     = merged;
        end

        // transaction sequencing
        unique case (ctrl_q.ph)
            PH_IDLE: begin
                if (cpu_req && !snp_valid && !can_hit) begin
                    ctrl_d.ph = PH_REQ;
                    if (victim_dirty) begin
                        ctrl_d.cmd  = BUS_WB;
                        ctrl_d.addr = {rd_tag[0], cpu_idx};
                    end else begin
                        ctrl_d.cmd  = cpu_we ? BUS_RDX : BUS_RD;
                        ctrl_d.addr = cpu_addr[ADDR_W-1:OFF_W];
                    end
                end
            end
            PH_REQ: begin
                if (snp_valid && s_hit && (snp_idx == pend_idx)) begin
                    ctrl_d.ph = PH_IDLE;
                end else if (bus_gnt) begin
                    ctrl_d.ph = PH_XFER;
                end
            end
            PH_XFER: begin
                if (bus_done) ctrl_d.ph = PH_IDLE;
            end
            default: ctrl_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q.ph   <= PH_IDLE;
            ctrl_q.cmd  <= BUS_NONE;
            ctrl_q.addr <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    // guards
    assert_snoop_blocks_hit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |-> !cpu_ready);

    assert_req_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt && !snp_valid) |=> (bus_req && $stable(bus_addr) && $stable(bus_cmd)));

    assert_no_ready_while_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !cpu_ready);

    assert_req_carries_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (bus_cmd != BUS_NONE));

    assert_wb_victim_dirty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_req) && bus_cmd == BUS_WB) |-> (rd_st[0] == COH_M));

    assert_flush_on_snoop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        snp_flush |-> (snp_valid && !bus_req || snp_valid));
endmodule

// File: tb/tb_msi_cache_ctrl.sv
module tb_msi_cache_ctrl;
    localparam int ADDR_W = 12, WORD_W = 32, LINE_WORDS = 2, LINES = 4;
    localparam int OFF_W = 1, IDX_W = 2, TAG_W = 9, LINE_W = 64, LADDR_W = 11;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cpu_req = 0, cpu_we = 0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [WORD_W-1:0] cpu_wdata = '0, cpu_rdata;
    logic cpu_ready, bus_req, bus_gnt = 0, bus_done = 0;
    logic [1:0] bus_cmd;
    logic [LADDR_W-1:0] bus_addr;
    logic [LINE_W-1:0] bus_wdata, bus_rdata = '0;
    logic snp_valid = 0;
    logic [1:0] snp_cmd = 0;
    logic [LADDR_W-1:0] snp_addr = '0;
    logic snp_flush;
    logic [LINE_W-1:0] snp_data;

    always #5 clk = ~clk;

    msi_cache_ctrl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS), .LINES(LINES)) dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_done(bus_done), .bus_rdata(bus_rdata),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .snp_flush(snp_flush), .snp_data(snp_data));

    // reference model: per-index state/tag/data, memory by line address
    int unsigned n_chk = 0, n_fail = 0, cyc = 0;
    bit finished = 0;
    logic [1:0]        m_st  [LINES];
    logic [TAG_W-1:0]  m_tag [LINES];
    logic [LINE_W-1:0] m_data[LINES];
    logic [LINE_W-1:0] mem [logic [LADDR_W-1:0]];

    function automatic logic [LINE_W-1:0] mem_rd(logic [LADDR_W-1:0] la);
        logic [31:0] b;
        b = 32'hC0DE_0000 + 32'(la) * 2;
        if (mem.exists(la)) return mem[la];
        return {b + 32'd1, b};
    endfunction

    function automatic logic [ADDR_W-1:0] mk(int tag, int idx, int off);
        return {TAG_W'(tag), IDX_W'(idx), OFF_W'(off)};
    endfunction

    task automatic chk(string rq, logic [LINE_W-1:0] act, logic [LINE_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
            summary();
        end
    end

    // snoop: drive during low phase, check combinational response, update model
    task automatic snoop(logic [1:0] cmd, logic [LADDR_W-1:0] la, string rq);
        int idx;
        bit hit;
        idx = int'(la[IDX_W-1:0]);
        hit = (m_st[idx] != 2'd0) && (m_tag[idx] == la[LADDR_W-1 -: TAG_W]);
        snp_valid = 1; snp_cmd = cmd; snp_addr = la;
        #1;
        chk({rq, " flush"}, 64'(snp_flush), 64'(hit && m_st[idx] == 2'd2));
        if (hit && m_st[idx] == 2'd2) begin
            chk({rq, " flush data"}, snp_data, m_data[idx]);
            mem[la] = m_data[idx];
        end
        if (cpu_req) chk("R11 ready low during snoop", 64'(cpu_ready), 64'd0);
        if (hit) begin
            if (cmd == 2'd2) m_st[idx] = 2'd0;
            else if (m_st[idx] == 2'd2) m_st[idx] = 2'd1;
        end
        @(negedge clk);
        snp_valid = 0;
        #1;
    endtask

    // processor access with bus responder; optional snoop injected at first request
    task automatic cpu_op(bit we, logic [ADDR_W-1:0] a, logic [WORD_W-1:0] wd,
                          bit expect_hit, string rq,
                          bit inj = 0, logic [1:0] inj_cmd = 0, logic [LADDR_W-1:0] inj_la = 0);
        int idx, k;
        logic [TAG_W-1:0] tg;
        logic [1:0] ecmd;
        logic [LADDR_W-1:0] ela;
        bit mhit;
        idx = int'(a[OFF_W +: IDX_W]);
        tg  = a[ADDR_W-1 -: TAG_W];
        cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        #1;
        chk({rq, " immediate ready"}, 64'(cpu_ready), 64'(expect_hit));
        k = 0;
        while (k < 60) begin
            k++;
            if (cpu_ready) begin
                mhit = (m_st[idx] != 0) && (m_tag[idx] == tg) && (m_st[idx] == 2'd2 || (!we && m_st[idx] == 2'd1));
                chk({rq, " model hit at ready"}, 64'(mhit), 64'd1);
                if (!we) chk({rq, " read data"}, 64'(cpu_rdata), 64'(m_data[idx][a[0]*WORD_W +: WORD_W]));
                else     m_data[idx][a[0]*WORD_W +: WORD_W] = wd;
                @(negedge clk);
                cpu_req = 0;
                #1;
                return;
            end
            if (bus_req) begin
                if (inj) begin
                    inj = 0;
                    snoop(inj_cmd, inj_la, "R10 snoop on pending");
                    continue;
                end
                if (m_st[idx] == 2'd2 && m_tag[idx] != tg) begin
                    ecmd = 2'd3; ela = {m_tag[idx], IDX_W'(idx)};
                end else begin
                    ecmd = we ? 2'd2 : 2'd1; ela = a[ADDR_W-1:OFF_W];
                end
                chk({rq, " bus cmd"}, 64'(bus_cmd), 64'(ecmd));
                chk({rq, " bus addr"}, 64'(bus_addr), 64'(ela));
                if (ecmd == 2'd3) chk("R8 write-back data", bus_wdata, m_data[idx]);
                for (int w = 0; w < 2; w++) begin
                    @(negedge clk); #1;
                    chk("R9 request held", 64'({bus_req, bus_cmd}), 64'({1'b1, ecmd}));
                end
                bus_gnt = 1;
                @(negedge clk);
                bus_gnt = 0;
                #1;
                chk("R9 no ready in transfer", 64'(cpu_ready), 64'd0);
                bus_rdata = mem_rd(ela);
                bus_done = 1;
                @(negedge clk);
                bus_done = 0;
                #1;
                if (ecmd == 2'd3) begin
                    mem[ela] = m_data[idx];
                    m_st[idx] = 2'd0;
                end else begin
                    m_st[idx]   = (ecmd == 2'd2) ? 2'd2 : 2'd1;
                    m_tag[idx]  = tg;
                    m_data[idx] = mem_rd(ela);
                end
                continue;
            end
            @(negedge clk);
            #1;
        end
        chk({rq, " completion"}, 64'd0, 64'd1);
        cpu_req = 0;
    endtask

    initial begin
        for (int i = 0; i < LINES; i++) begin
            m_st[i] = 0; m_tag[i] = 0; m_data[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #1;
        chk("R1 reset bus_req", 64'(bus_req), 64'd0);
        chk("R1 reset cpu_ready", 64'(cpu_ready), 64'd0);
        chk("R1 reset snp_flush", 64'(snp_flush), 64'd0);
        chk("R1 reset bus_cmd", 64'(bus_cmd), 64'd0);

        cpu_op(0, mk(1, 0, 0), 0, 0, "R1 R2 cold read miss");
        cpu_op(0, mk(1, 0, 1), 0, 1, "R4 read hit in S");
        cpu_op(1, mk(1, 0, 1), 32'h1111_0001, 0, "R3 write on S upgrades");
        cpu_op(0, mk(1, 0, 1), 0, 1, "R3 R4 read of written word");
        cpu_op(1, mk(1, 0, 0), 32'h2222_0002, 1, "R4 write hit in M");

        snoop(2'd1, {9'd1, 2'd0}, "R5 snoop read on M");
        cpu_op(1, mk(1, 0, 0), 32'h3333_0003, 0, "R5 write after downgrade");
        snoop(2'd2, {9'd1, 2'd0}, "R6 snoop rdx on M");
        cpu_op(0, mk(1, 0, 0), 0, 0, "R6 read after invalidate");
        snoop(2'd1, {9'd1, 2'd0}, "R7 snoop read on S");
        cpu_op(0, mk(1, 0, 1), 0, 1, "R7 S kept after snoop read");
        snoop(2'd2, {9'd5, 2'd0}, "R12 snoop tag mismatch");
        snoop(2'd2, {9'd1, 2'd3}, "R12 snoop on invalid line");
        cpu_op(0, mk(1, 0, 0), 0, 1, "R12 line unaffected");
        snoop(2'd2, {9'd1, 2'd0}, "R7 snoop rdx on S");
        cpu_op(0, mk(1, 0, 0), 0, 0, "R7 read misses after invalidate");

        cpu_op(1, mk(2, 1, 1), 32'hBEEF_0004, 0, "R3 write miss on I");
        cpu_op(0, mk(3, 1, 0), 0, 0, "R8 conflict miss on dirty line");
        cpu_op(0, mk(2, 1, 1), 0, 0, "R8 written-back data returns");

        cpu_op(1, mk(4, 2, 0), 32'hFACE_0005, 0, "R3 write miss idx2");
        cpu_op(0, mk(6, 2, 1), 0, 0, "R10 pending write-back withdrawn",
               1, 2'd1, {9'd4, 2'd2});
        cpu_op(0, mk(4, 2, 0), 0, 0, "R10 flushed data refetched");

        // R11: snoop in the same cycle as a hit
        cpu_req = 1; cpu_we = 0; cpu_addr = mk(4, 2, 0);
        snoop(2'd1, {9'd7, 2'd3}, "R11 snoop against hit");
        chk("R11 hit completes after snoop", 64'(cpu_ready), 64'd1);
        @(negedge clk);
        cpu_req = 0;
        #1;

        repeat (2) @(negedge clk);
        summary();
    end
endmodule